// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a memory burst. A start pulse loads a start column together with a length code and an order select. From the next cycle on, the block presents one column per clock with a valid flag. A last flag marks the final beat of a fixed-length burst. Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. In sequential order the low bits count upward and wrap with no carry into the higher bits. In interleave order the low bits are XORed with the beat number. A full-page burst counts linearly around the whole page and keeps running until a stop request ends it.

A new start may arrive in any cycle. It drops whatever burst is running and begins a complete new burst at the new column. A stop request has meaning only for a full-page burst. If a stop arrives during a fixed-length burst, the block raises an error pulse and the burst continues unchanged. All outputs are registered.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `colValid`, `colLast` and `stopErr` are low.
- R2: A start sampled on a clock edge makes `colValid` high and `colOut` equal to the sampled `startCol` in the following cycle. A fixed burst keeps `colValid` high for exactly its length in cycles.
- R3: The `burstLen` codes are 3'd0 for 1 beat, 3'd1 for 2, 3'd2 for 4, 3'd3 for 8 and 3'd7 for full page. Codes 3'd4 to 3'd6 behave as 1 beat.
- R4: With `burstType`=0 (sequential) and length L of 2, 4 or 8, beat i carries the start column with its low log2(L) bits replaced by (start + i) mod L. The bits above stay unchanged.
- R5: With `burstType`=1 (interleave) and length L of 2, 4 or 8, beat i carries the start column with its low log2(L) bits XORed with i.
- R6: `colLast` is high only on the final beat of a fixed burst. For a 1-beat burst it is high in the same cycle as the single beat. After a last beat with no new start, `colValid` falls.
- R7: A full-page burst outputs (start + i) mod 2^COL_W on beat i, whatever `burstType` is. It never raises `colLast` and runs until it is stopped or restarted.
- R8: A stop sampled during a full-page burst makes `colValid` low from the next cycle, with no error.
- R9: A stop sampled during a fixed burst without a start raises `stopErr` for one cycle in the next cycle and leaves the burst's addresses and length unchanged. A stop while idle has no effect.
- R10: A start sampled during a burst, including on its last beat or together with a stop, discards the old burst and begins a full new burst from the new column. No `stopErr` is raised in that case.
- R11: `burstLen` and `burstType` are sampled only with a start. Changes to them during a burst do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| start | input | 1 | Begin a new burst at `startCol` |
| startCol | input | COL_W | Start column |
| burstLen | input | 3 | Length code (see R3) |
| burstType | input | 1 | 0 sequential, 1 interleave |
| stop | input | 1 | End a full-page burst |
| colOut | output | COL_W | Column of the current beat |
| colValid | output | 1 | A beat is presented this cycle |
| colLast | output | 1 | Final beat of a fixed burst |
| stopErr | output | 1 | Stop arrived during a fixed burst |

## Verification
A restart can coincide with a burst's final beat. It can also coincide with a stop request. In both cases the start must win: the new column appears on the next cycle and no error is raised. The bench drives a start exactly on a last beat, and drives start together with stop in the middle of a full-page run. A behavioural model applies start-before-stop priority and compares column, valid, last and error on every cycle, so a wrong priority shows up as a mismatch in the cycle that follows.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Strobes from control to the address datapath
  typedef struct packed {
    logic load;  // capture start column and mode
    logic step;  // advance to the next beat
  } bcgStrobe_t;

  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_FULL_CODE = 3'd7;
  localparam int MAX_FIXED_LOG = 3;  // longest fixed burst is 2**3 beats
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  stop,
  input  logic [LEN_CODE_W-1:0] lenCode,
  output bcgStrobe_t            strobe,
  output logic                  busy,
  output logic                  lastBeat,
  output logic                  stopErr
);
  localparam int REM_W = MAX_FIXED_LOG;

  logic             fullPage;
  logic [REM_W-1:0] remain;
  logic             isFull;
  logic [REM_W-1:0] lenMinus1;

  // decode of the requested length at start time
  always_comb begin
    isFull = (lenCode == LEN_FULL_CODE);
    if (lenCode <= LEN_CODE_W'(MAX_FIXED_LOG))
      lenMinus1 = REM_W'((1 << lenCode) - 1);
    else
      lenMinus1 = '0;
  end

  always_comb begin
    strobe.load = start;
    strobe.step = !start && busy && (fullPage ? !stop : (remain != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      fullPage <= 1'b0;
      remain   <= '0;
      lastBeat <= 1'b0;
      stopErr  <= 1'b0;
    end else begin
      stopErr <= stop && !start && busy && !fullPage;
      if (start) begin
        busy     <= 1'b1;
        fullPage <= isFull;
        remain   <= isFull ? '0 : lenMinus1;
        lastBeat <= !isFull && (lenMinus1 == '0);
      end else if (busy) begin
        if (fullPage) begin
          if (stop) busy <= 1'b0;
        end else if (remain == '0) begin
          busy     <= 1'b0;
          lastBeat <= 1'b0;
        end else begin
          remain   <= remain - 1'b1;
          lastBeat <= (remain == REM_W'(1));
        end
      end
    end
  end
endmodule

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bcgStrobe_t            strobe,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  ilvSel,
  output logic [COL_W-1:0]      colOut
);
  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] wrapMask;
  logic [COL_W-1:0] beatOff;
  logic             ilvMode;
  logic             fullMode;

  logic [COL_W-1:0] maskIn;
  logic [COL_W-1:0] offNext;
  logic [COL_W-1:0] colNext;

  // low-bit mask of the block the burst wraps in
  always_comb begin
    if (lenCode == LEN_FULL_CODE)
      maskIn = '1;
    else if (lenCode <= LEN_CODE_W'(MAX_FIXED_LOG))
      maskIn = COL_W'((1 << lenCode) - 1);
    else
      maskIn = '0;
  end

  always_comb begin
    offNext = beatOff + 1'b1;
    if (fullMode)
      colNext = baseCol + offNext;
    else if (ilvMode)
      colNext = (baseCol & ~wrapMask) | ((baseCol ^ offNext) & wrapMask);
    else
      colNext = (baseCol & ~wrapMask) | ((baseCol + offNext) & wrapMask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseCol  <= '0;
      wrapMask <= '0;
      beatOff  <= '0;
      ilvMode  <= 1'b0;
      fullMode <= 1'b0;
      colOut   <= '0;
    end else if (strobe.load) begin
      baseCol  <= startCol;
      wrapMask <= maskIn;
      beatOff  <= '0;
      ilvMode  <= ilvSel;
      fullMode <= (lenCode == LEN_FULL_CODE);
      colOut   <= startCol;
    end else if (strobe.step) begin
      beatOff <= offNext;
      colOut  <= colNext;
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] burstLen,
  input  logic                  burstType,
  input  logic                  stop,
  output logic [COL_W-1:0]      colOut,
  output logic                  colValid,
  output logic                  colLast,
  output logic                  stopErr
);
  bcgStrobe_t strobe;

  bcg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stop     (stop),
    .lenCode  (burstLen),
    .strobe   (strobe),
    .busy     (colValid),
    .lastBeat (colLast),
    .stopErr  (stopErr)
  );

  bcg_datapath #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .startCol (startCol),
    .lenCode  (burstLen),
    .ilvSel   (burstType),
    .colOut   (colOut)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [COL_W-1:0]      startCol,
  input logic [LEN_CODE_W-1:0] burstLen,
  input logic                  burstType,
  input logic                  stop,
  input logic [COL_W-1:0]      colOut,
  input logic                  colValid,
  input logic                  colLast,
  input logic                  stopErr
);
  // R6
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    colLast |-> colValid);

  // R2
  start_loads_col_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (colValid && colOut == $past(startCol)));

  // R6
  single_beat_last_chk: assert property (@(posedge clk) disable iff (rst)
    (start && burstLen == 3'd0) |=> colLast);

  // R7
  full_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (start && burstLen == LEN_FULL_CODE) |=> !colLast);

  // R9
  err_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    stopErr |-> ($past(stop) && $past(colValid) && !$past(start)));

  // R6
  after_last_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (colLast && !start) |=> !colValid);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int COL_W = 9;
  localparam int PAGE = 1 << COL_W;

  logic             clk = 0;
  logic             rst = 1;
  logic             start = 0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       burstLen = '0;
  logic             burstType = 0;
  logic             stop = 0;
  logic [COL_W-1:0] colOut;
  logic             colValid, colLast, stopErr;

  burst_col_gen #(.COL_W(COL_W)) dut (.*);

  always #4 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // behavioural reference
  bit mBusy, mErr, mIlv;
  int mLen, mIdx, mBase;

  function automatic int lenOf(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int expCol();
    if (mLen == 0) return (mBase + mIdx) % PAGE;
    if (mIlv) return mBase ^ mIdx;
    return (mBase & ~(mLen - 1)) | ((mBase + mIdx) & (mLen - 1));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mErr = 0; mIdx = 0; mLen = 1;
    end else begin
      mErr = stop && !start && mBusy && mLen != 0;
      if (start) begin
        mBusy = 1; mIdx = 0; mBase = int'(startCol);
        mLen = lenOf(burstLen); mIlv = burstType;
      end else if (mBusy) begin
        if (mLen == 0) begin
          if (stop) mBusy = 0; else mIdx++;
        end else if (mIdx == mLen - 1) mBusy = 0;
        else mIdx++;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit eLast;
      eLast = mBusy && mLen != 0 && mIdx == mLen - 1;
      check(curReq, "colValid", int'(colValid), int'(mBusy));
      check(curReq, "colLast", int'(colLast), int'(eLast));
      check(curReq, "stopErr", int'(stopErr), int'(mErr));
      if (mBusy) check(curReq, "colOut", int'(colOut), expCol());
    end
  end

  task automatic drive(input logic st, input logic [COL_W-1:0] c,
                       input logic [2:0] l, input logic ty, input logic sp);
    @(negedge clk); #1;
    start = st; startCol = c; burstLen = l; burstType = ty; stop = sp;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, startCol, burstLen, burstType, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin
      @(posedge clk); wd++;
    end
    mismatched++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "colValid in reset", int'(colValid), 0);
    check("R1", "colLast in reset", int'(colLast), 0);
    check("R1", "stopErr in reset", int'(stopErr), 0);
    drive(0, 0, 0, 0, 0);
    rst = 0;
    idle(2);

    // R4: sequential wrap, lengths 2/4/8
    curReq = "R4";
    for (int l = 1; l <= 3; l++) begin
      drive(1, 9'h0AD, 3'(l), 0, 0);
      idle(10);
    end
    drive(1, 9'h1FF, 3'd3, 0, 0); idle(10);

    // R5: interleave order
    curReq = "R5";
    for (int l = 1; l <= 3; l++) begin
      drive(1, 9'h136, 3'(l), 1, 0);
      idle(10);
    end

    // R3 / R6: single beat and reserved codes
    curReq = "R6";
    drive(1, 9'h055, 3'd0, 0, 0); idle(3);
    curReq = "R3";
    for (int l = 4; l <= 6; l++) begin
      drive(1, 9'(l * 7), 3'(l), 1, 0);
      idle(3);
    end

    // R7 / R8: full page across the top of the page, then stop
    curReq = "R7";
    drive(1, 9'h1FC, 3'd7, 1, 0); idle(20);
    curReq = "R8";
    drive(0, 0, 3'd7, 1, 1); idle(4);

    // R9: stop during fixed burst, stop while idle
    curReq = "R9";
    drive(1, 9'h020, 3'd3, 0, 0); idle(2);
    drive(0, 0, 3'd3, 0, 1); idle(8);
    drive(0, 0, 3'd0, 0, 1); idle(3);

    // R10: restart mid burst, on last beat, together with stop
    curReq = "R10";
    drive(1, 9'h0F3, 3'd3, 1, 0); idle(3);
    drive(1, 9'h102, 3'd2, 0, 0); idle(2);
    drive(1, 9'h0C1, 3'd1, 0, 0); idle(5);
    drive(1, 9'h010, 3'd7, 0, 0); idle(5);
    drive(1, 9'h044, 3'd2, 1, 1); idle(6);

    // R11: mode inputs change mid-burst
    curReq = "R11";
    drive(1, 9'h0B5, 3'd3, 0, 0);
    drive(0, 0, 3'd0, 1, 0);
    drive(0, 0, 3'd7, 1, 0);
    idle(8);

    // R2: back-to-back bursts
    curReq = "R2";
    drive(1, 9'h007, 3'd2, 0, 0);
    idle(3);
    drive(1, 9'h008, 3'd1, 1, 0);
    idle(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule